// File: doc/BRIEF.md
# Per-Target Privilege Access Guard

This block sits on the request path between a bus master and a set of protected targets. The targets are instruction memory, data memory, the CPU control register, a miscellaneous register group, an interrupt register group, a method/context register group, the security control register, the watchdog registers and external memory. Each target has an 8-bit control word. The word holds a minimum privilege for reads, a minimum privilege for writes, and two sticky flags that record refused reads and refused writes.

Every request carries the requester's security mode. The guard decodes the target from the upper address bits and compares the mode against the threshold for the request's direction. An allowed request is forwarded to the target side in the same cycle. A refused request is blocked, answered with zero data and flagged. Software reads the control words from a small configuration window. It changes the thresholds, and clears the flags by writing 1 to them, through the same request port.

Top module: `priv_guard`

## Requirements
- R1: Control word layout: bits [2:0] hold the read threshold, bit 3 is the read-violation flag, bits [6:4] hold the write threshold, and bit 7 is the write-violation flag. Word i is read, zero-extended, at region 0, byte offset 4*i, in the same cycle as the request.
- R2: Address bits [15:12] form the region number. Region r, for r from 1 to 9, guards target r-1, in this order: instruction memory, data memory, CPU control, miscellaneous group, interrupt group, method/context group, security control, watchdog, external memory.
- R3: The mode encoding is 0 = non-secure, 2 = light secure, 3 = heavy secure, and each of these ranks at its own value. An access to a guarded target is allowed only when that rank is greater than or equal to the threshold for its direction, so thresholds 4 to 7 refuse every mode.
- R4: Mode 1 is invalid. It is refused on every checked access, whatever the threshold.
- R5: A refused request does not raise tgt_valid_o, raises deny_o, and returns zero on rsp_rdata_o.
- R6: A refused read sets bit 3 and a refused write sets bit 7 of the addressed target's word only. The flag becomes visible from the next cycle.
- R7: A flag stays set until an allowed configuration write puts a 1 in its bit position. A configuration write is allowed only when the mode meets that word's own write threshold. Writing 0 to a flag bit leaves it unchanged. A refused configuration write leaves both thresholds unchanged and sets that word's bit 7.
- R8: An allowed configuration write loads both thresholds from bits [2:0] and [6:4]. The new values govern requests from the next cycle on.
- R9: Addresses in regions 10 to 15 pass to the target side unchecked, in any mode, including mode 1.
- R10: Configuration reads are always allowed. Any allowed configuration access returns the word as held before the access and is never forwarded to the target side. A configuration index of 9 or more reads as zero, and writes to it are ignored.
- R11: After reset every control word holds 0x30: any mode may read, only heavy secure may write, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mode_i | input | 2 | Requester security mode |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data returned to the master |
| deny_o | output | 1 | Request refused |
| tgt_valid_o | output | 1 | Forwarded request to the target side |
| tgt_write_o | output | 1 | Forwarded direction |
| tgt_addr_o | output | ADDR_W | Forwarded address |
| tgt_wdata_o | output | DATA_W | Forwarded write data |
| tgt_rdata_i | input | DATA_W | Read data from the target side |

## Verification
A corrupted threshold shows up on the next request to that target, as a wrong deny_o or a stray tgt_valid_o. A configuration read exposes the stored word in the same cycle. A flag that is lost, or set on the wrong target, is visible one cycle after the offending request when its word is read back. A clear that fails to act, or acts without write privilege, is visible on the read that follows that write. Mode 1 and the unguarded regions are driven against each threshold state, so a wrong decode appears at once as a forwarding error.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;

  typedef enum logic [1:0] {
    MODE_NS  = 2'd0,
    MODE_BAD = 2'd1,
    MODE_LS  = 2'd2,
    MODE_HS  = 2'd3
  } sec_mode_e;

  typedef struct packed {
    logic       wr_viol;
    logic [2:0] wr_thr;
    logic       rd_viol;
    logic [2:0] rd_thr;
  } ctl_word_t;

  localparam int unsigned CTL_W = $bits(ctl_word_t);

  function automatic logic mode_ok(logic [1:0] mode, logic [2:0] thr);
    return (mode != MODE_BAD) && ({1'b0, mode} >= thr);
  endfunction

endpackage

// File: rtl/priv_decode.sv
module priv_decode #(
  parameter int unsigned RGN_W = 4,
  parameter int unsigned N_TGT = 9,
  parameter int unsigned IDX_W = 4
) (
  input  logic [RGN_W-1:0] rgn_i,
  input  logic [IDX_W-1:0] word_i,
  output logic             cfg_hit_o,
  output logic             cfg_ok_o,
  output logic             tgt_hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [RGN_W-1:0] rgn_m1;

  always_comb begin
    rgn_m1    = rgn_i - 1'b1;
    cfg_hit_o = (rgn_i == '0);
    cfg_ok_o  = cfg_hit_o && (int'(word_i) < int'(N_TGT));
    tgt_hit_o = (rgn_i != '0) && (int'(rgn_i) <= int'(N_TGT));
    idx_o     = cfg_hit_o ? word_i : rgn_m1[IDX_W-1:0];
  end
endmodule

// File: rtl/priv_ctl_word.sv
module priv_ctl_word
  import priv_guard_pkg::*;
#(
  parameter logic [2:0] RST_RD_THR = 3'd0,
  parameter logic [2:0] RST_WR_THR = 3'd3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  ctl_word_t wdata_i,
  input  logic      rd_set_i,
  input  logic      wr_set_i,
  output ctl_word_t word_o
);
  ctl_word_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '{wr_viol: 1'b0, wr_thr: RST_WR_THR, rd_viol: 1'b0, rd_thr: RST_RD_THR};
    end else begin
      if (we_i) begin
        q.rd_thr <= wdata_i.rd_thr;
        q.wr_thr <= wdata_i.wr_thr;
      end
      // set wins; clear needs an allowed write with a 1 in the flag position
      q.rd_viol <= rd_set_i | (q.rd_viol & ~(we_i & wdata_i.rd_viol));
      q.wr_viol <= wr_set_i | (q.wr_viol & ~(we_i & wdata_i.wr_viol));
    end
  end

  assign word_o = q;
endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RGN_W      = 4,
  parameter int unsigned N_TGT      = 9,
  parameter logic [2:0]  RST_RD_THR = 3'd0,
  parameter logic [2:0]  RST_WR_THR = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_mode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              deny_o,
  output logic              tgt_valid_o,
  output logic              tgt_write_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  input  logic [DATA_W-1:0] tgt_rdata_i
);
  localparam int unsigned IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;

  logic             cfg_hit, cfg_ok, tgt_hit;
  logic [IDX_W-1:0] idx;
  ctl_word_t [N_TGT-1:0] ctl_q;
  ctl_word_t        cur;
  logic [2:0]       thr;
  logic             checked, allow;

  priv_decode #(.RGN_W(RGN_W), .N_TGT(N_TGT), .IDX_W(IDX_W)) u_dec (
    .rgn_i     (req_addr_i[ADDR_W-1 -: RGN_W]),
    .word_i    (req_addr_i[IDX_W+1:2]),
    .cfg_hit_o (cfg_hit),
    .cfg_ok_o  (cfg_ok),
    .tgt_hit_o (tgt_hit),
    .idx_o     (idx)
  );

  always_comb begin
    cur = '0;
    for (int i = 0; i < int'(N_TGT); i++) begin
      if (idx == IDX_W'(i)) cur = ctl_q[i];
    end
    thr     = req_write_i ? cur.wr_thr : cur.rd_thr;
    // config reads are open; config writes use the word's own write threshold
    checked = tgt_hit | (cfg_ok & req_write_i);
    allow   = ~checked | mode_ok(req_mode_i, thr);
  end

  assign deny_o      = req_valid_i & ~allow;
  assign tgt_valid_o = req_valid_i & allow & ~cfg_hit;
  assign tgt_write_o = req_write_i;
  assign tgt_addr_o  = req_addr_i;
  assign tgt_wdata_o = req_wdata_i;

  always_comb begin
    if (deny_o)       rsp_rdata_o = '0;
    else if (cfg_hit) rsp_rdata_o = cfg_ok ? DATA_W'(cur) : '0;
    else              rsp_rdata_o = tgt_rdata_i;
  end

  for (genvar g = 0; g < N_TGT; g++) begin : g_word
    logic sel;
    assign sel = (tgt_hit | cfg_ok) & (idx == IDX_W'(g));
    priv_ctl_word #(.RST_RD_THR(RST_RD_THR), .RST_WR_THR(RST_WR_THR)) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (req_valid_i & req_write_i & cfg_ok & allow & (idx == IDX_W'(g))),
      .wdata_i  (ctl_word_t'(req_wdata_i[CTL_W-1:0])),
      .rd_set_i (deny_o & ~req_write_i & sel),
      .wr_set_i (deny_o & req_write_i & sel),
      .word_o   (ctl_q[g])
    );
  end
endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RGN_W  = 4,
  parameter int unsigned N_TGT  = 9,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [1:0]        req_mode_i,
  input logic [RGN_W-1:0]  rgn_i,
  input logic [IDX_W-1:0]  word_i,
  input logic              clr_rd_i,
  input logic              clr_wr_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              deny_o,
  input logic              tgt_valid_o,
  input logic [N_TGT*8-1:0] ctl_i
);
  logic guarded;
  assign guarded = (rgn_i != '0) && (int'(rgn_i) <= int'(N_TGT));

  AST_DENY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && deny_o |-> !tgt_valid_o && rsp_rdata_o == '0); // R5

  AST_BAD_MODE_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_mode_i == 2'd1 && guarded |-> deny_o); // R4

  AST_OPEN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && int'(rgn_i) > int'(N_TGT) |-> tgt_valid_o && !deny_o); // R9

  AST_CFG_READ_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && rgn_i == '0 |-> !deny_o && !tgt_valid_o); // R10

  for (genvar g = 0; g < N_TGT; g++) begin : g_chk
    logic clr_rd, clr_wr;
    assign clr_rd = req_valid_i && req_write_i && !deny_o && rgn_i == '0 &&
                    word_i == IDX_W'(g) && clr_rd_i;
    assign clr_wr = req_valid_i && req_write_i && !deny_o && rgn_i == '0 &&
                    word_i == IDX_W'(g) && clr_wr_i;

    AST_RD_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && deny_o && !req_write_i && int'(rgn_i) == g + 1 |=> ctl_i[g*8+3]); // R6

    AST_WR_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && deny_o && req_write_i && int'(rgn_i) == g + 1 |=> ctl_i[g*8+7]); // R6

    AST_RD_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_i[g*8+3] |=> ctl_i[g*8+3] || $past(clr_rd)); // R7

    AST_WR_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_i[g*8+7] |=> ctl_i[g*8+7] || $past(clr_wr)); // R7
  end
endmodule

bind priv_guard priv_guard_chk #(
  .DATA_W (DATA_W),
  .RGN_W  (RGN_W),
  .N_TGT  (N_TGT),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_mode_i  (req_mode_i),
  .rgn_i       (req_addr_i[ADDR_W-1 -: RGN_W]),
  .word_i      (req_addr_i[IDX_W+1:2]),
  .clr_rd_i    (req_wdata_i[3]),
  .clr_wr_i    (req_wdata_i[7]),
  .rsp_rdata_o (rsp_rdata_o),
  .deny_o      (deny_o),
  .tgt_valid_o (tgt_valid_o),
  .ctl_i       (ctl_q)
);

// File: tb/sim_priv_guard.sv
module sim_priv_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata, tgt_wdata, tgt_rdata;
  logic        deny, tgt_valid, tgt_write;
  logic [15:0] tgt_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic        deny;
    logic        tv;
    logic [31:0] rd;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  // target side model: data derived from the forwarded address
  assign tgt_rdata = {16'hC0DE, tgt_addr};

  priv_guard u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_mode_i(req_mode),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rsp_rdata), .deny_o(deny), .tgt_valid_o(tgt_valid),
    .tgt_write_o(tgt_write), .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata),
    .tgt_rdata_i(tgt_rdata)
  );

  task automatic issue(input logic [1:0] m, input logic w, input logic [15:0] a,
                       input logic [31:0] d, input logic e_deny, input logic e_tv,
                       input logic [31:0] e_rd, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_mode = m; req_addr = a; req_wdata = d;
    e.tag = tag; e.deny = e_deny; e.tv = e_tv; e.rd = e_rd;
    sb_q.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  function automatic logic [31:0] pass_rd(logic [15:0] a);
    return {16'hC0DE, a};
  endfunction

  // monitor: compares combinational response mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (deny !== e.deny || tgt_valid !== e.tv || rsp_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: deny=%0b tv=%0b rd=%h expected deny=%0b tv=%0b rd=%h",
                   e.tag, deny, tgt_valid, rsp_rdata, e.deny, e.tv, e.rd);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 R1: reset word
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'h30, "R11 reset word0");
    issue(2'd0, 0, 16'h1004, 0, 0, 1, pass_rd(16'h1004), "R3 NS read imem rd_thr0");
    issue(2'd0, 1, 16'h1008, 32'h55, 1, 0, 0, "R5 NS write imem refused");
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'hB0, "R6 write flag set");
    issue(2'd0, 0, 16'h0004, 0, 0, 0, 32'h30, "R6 other word untouched");
    issue(2'd3, 1, 16'h0000, 32'h22, 0, 0, 32'hB0, "R10 cfg write returns old word");
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'hA2, "R8 R7 thresholds loaded, flag kept");
    issue(2'd2, 0, 16'h1010, 0, 0, 1, pass_rd(16'h1010), "R3 LS equals threshold");
    issue(2'd0, 0, 16'h1010, 0, 1, 0, 0, "R3 NS below threshold");
    issue(2'd1, 0, 16'h1010, 0, 1, 0, 0, "R4 invalid mode refused");
    issue(2'd1, 0, 16'hF000, 0, 0, 1, pass_rd(16'hF000), "R9 invalid mode unguarded pass");
    issue(2'd0, 1, 16'h0000, 32'hFF, 1, 0, 0, "R7 NS cfg write refused");
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'hAA, "R7 refused cfg write no change");
    issue(2'd2, 1, 16'h0000, 32'h8A, 0, 0, 32'hAA, "R7 LS w1c write");
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'h02, "R7 flags cleared");
    issue(2'd0, 1, 16'h1000, 32'h1, 0, 1, pass_rd(16'h1000), "R8 wr_thr0 NS write");
    issue(2'd3, 1, 16'h0020, 32'h37, 0, 0, 32'h30, "R2 cfg8 write");
    issue(2'd3, 0, 16'h9000, 0, 1, 0, 0, "R3 thr7 refuses HS");
    issue(2'd0, 0, 16'h0020, 0, 0, 0, 32'h3F, "R2 R10 ext mem word readable");
    issue(2'd0, 0, 16'h0030, 0, 0, 0, 0, "R10 out of range cfg read");
    issue(2'd0, 1, 16'h0030, 32'hFF, 0, 0, 0, "R10 out of range cfg write");
    issue(2'd0, 1, 16'hA000, 32'h9, 0, 1, pass_rd(16'hA000), "R9 region 10 pass");
    issue(2'd2, 1, 16'h2000, 0, 1, 0, 0, "R2 dmem write LS refused");
    issue(2'd0, 0, 16'h0004, 0, 0, 0, 32'hB0, "R2 R6 dmem word flagged");
    issue(2'd0, 0, 16'h0000, 0, 0, 0, 32'h02, "R6 imem word unaffected");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule